// File: doc/BRIEF.md
# Host-DSP Mailbox and Mode Register File

This block is the small register file that sits between a host bus and a signal processor on a plug-in coprocessor card. The host reaches it through a memory-mapped window, and a parameter adds an I/O-space alias of the same registers. The DSP reaches it through its own I/O address space. After reset the card is in standard mode. The host then sees only the signature register, and the DSP side is inert. When the host writes a magic key to the signature register, the card enters smart mode. In smart mode a control register, a status word, a pair of one-word mailboxes, a buffered bit-I/O port and a system configuration word all become live.

The mode is held by a two-state machine, `MODE_STD` and `MODE_SMART`. The transition `KEY_WRITE` leads from `MODE_STD` to `MODE_SMART` and is taken on a host memory write of 0xA320 to offset 0x400. The transition `MODE_DROP` leads from `MODE_SMART` to `MODE_STD` and is taken on a host write to the control register with bit 0 clear. Each mailbox is a second two-state machine, `MB_EMPTY` and `MB_FULL`. The transition `POST` (a writer stores a word) leads to `MB_FULL`, the transition `TAKE` (the opposite side reads) leads to `MB_EMPTY`, and `FLUSH` (standard mode) forces `MB_EMPTY`. When `POST` and `TAKE` arrive in the same cycle, `POST` wins.

Both sides may poll the full flags, or may use them as interrupts gated by enable bits in the control register. Register reads are combinational within the access cycle. State changes take effect at the clock edge that ends the access.

Top module: `hostdsp_mailbox_regs`

## Requirements
- R1: After reset the card is in standard mode, both interrupts are low, syscfg_o reads 0x0001, bio_pins_o is 0, and a host read of offset 0x400 returns 0.
- R2: A host memory write of 0xA320 to offset 0x400 enters smart mode. After that, offset 0x400 reads 0xA320 and control bit 0 reads 1.
- R3: A host write of any other value to offset 0x400 leaves the mode unchanged, in either mode.
- R4: In standard mode every host offset other than 0x400 reads 0 and ignores writes, and every DSP access reads 0 and ignores writes.
- R5: A host write to control (0x002) with bit 0 clear returns the card to standard mode. The next entry into smart mode then finds both mailboxes empty and both interrupt enables clear.
- R6: A host write to 0x008 fills the DSP-bound mailbox. A DSP read of 0x51 returns that word and empties the mailbox. Host offset 0x008 reads as 0.
- R7: A DSP write to 0x50 fills the host-bound mailbox. A host read of 0x006 returns that word and empties the mailbox.
- R8: When a mailbox is written and read by the opposite side in the same cycle, it ends full and holds the new word.
- R9: Control bit 1 enables host_irq_o, which is high while the host-bound mailbox is full. Control bit 2 enables dsp_irq_o, which is high while the DSP-bound mailbox is full. The status word, at host offset 0x004 and at DSP address 0x52, holds bit 0 = host-bound full, bit 1 = DSP-bound full and bit 2 = smart mode.
- R10: Host offsets 0x00A to 0x00F and DSP addresses 0x55 to 0x58 read 0, and writes to them change no register.
- R11: A DSP write to 0x53 drives bio_pins_o from the next cycle. A DSP read of 0x53 returns bio_pins_i as registered one cycle earlier.
- R12: The DSP reads and writes the configuration word at 0x54. Bit 0 (page zero enable) always reads 1, both there and on syscfg_o.
- R13: With h_io high, the host reaches control, status and the mailboxes at the same offsets, but the signature register is not reachable, so an I/O write of the key does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_io | input | 1 | Host access is in I/O space (alias) |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | HAW (11) | Host byte offset |
| h_wdata | input | DW (16) | Host write data |
| h_rdata | output | DW (16) | Host read data, valid in the access cycle |
| d_sel | input | 1 | DSP I/O access strobe |
| d_we | input | 1 | DSP write (1) or read (0) |
| d_addr | input | DAW (8) | DSP I/O address |
| d_wdata | input | DW (16) | DSP write data |
| d_rdata | output | DW (16) | DSP read data, valid in the access cycle |
| bio_pins_i | input | DW (16) | Bit-I/O input pins |
| bio_pins_o | output | DW (16) | Bit-I/O output latch |
| syscfg_o | output | DW (16) | Configuration word, bit 0 held at 1 |
| smart_mode_o | output | 1 | High in smart mode (DSP enabled) |
| host_irq_o | output | 1 | Interrupt to the host |
| dsp_irq_o | output | 1 | Interrupt to the DSP |

## Verification
A wrong mode state shows at once: the next host read of the control or status offset returns 0 where 1 was expected in bit 0 or bit 2, or the reverse. A stuck or lost mailbox flag shows on the next status read from either side and on the interrupt pins in the same cycle as the flag changes. A wrong collision priority shows as an empty flag, or a stale word, on the first read after the collision cycle. A bit-I/O or configuration fault shows on the output pins one cycle after the DSP write, or on the read-back.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
    typedef enum logic {MODE_STD, MODE_SMART} mode_e;
    typedef enum logic {MB_EMPTY, MB_FULL} mb_e;

    localparam logic [15:0] SIG_KEY = 16'hA320;

    // host byte offsets
    localparam int H_SIG  = 'h400;
    localparam int H_CTRL = 'h002;
    localparam int H_STAT = 'h004;
    localparam int H_TX   = 'h006;
    localparam int H_RX   = 'h008;

    // DSP I/O addresses
    localparam int D_TX   = 'h50;
    localparam int D_RX   = 'h51;
    localparam int D_STAT = 'h52;
    localparam int D_BIO  = 'h53;
    localparam int D_CFG  = 'h54;
endpackage

// File: rtl/hdm_mode_fsm.sv
module hdm_mode_fsm
    import hdm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sig_wr,
    input  logic [DW-1:0] sig_data,
    input  logic          ctrl_wr,
    input  logic [2:0]    ctrl_bits,
    output logic          smart_o,
    output logic          host_ie_o,
    output logic          dsp_ie_o
);
    mode_e state_q, state_d;
    logic  host_ie_q, dsp_ie_q;
    logic  key_hit;

    assign key_hit = sig_wr && (sig_data == DW'(SIG_KEY));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_STD:   if (key_hit) state_d = MODE_SMART;
            MODE_SMART: if (ctrl_wr && !ctrl_bits[0]) state_d = MODE_STD;
        endcase
    end

    // state register and enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= MODE_STD;
            host_ie_q <= 1'b0;
            dsp_ie_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == MODE_STD) begin
                host_ie_q <= 1'b0;
                dsp_ie_q  <= 1'b0;
            end else if (state_q == MODE_SMART && ctrl_wr) begin
                host_ie_q <= ctrl_bits[1];
                dsp_ie_q  <= ctrl_bits[2];
            end
        end
    end

    // outputs
    always_comb begin
        smart_o   = (state_q == MODE_SMART);
        host_ie_o = host_ie_q;
        dsp_ie_o  = dsp_ie_q;
    end

    // R2: smart mode is only entered by the key
    a_r2_enter_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smart_o) |-> $past(sig_wr && sig_data == DW'(SIG_KEY)));
    // R5: smart mode is only left by clearing control bit 0
    a_r5_leave_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smart_o) |-> $past(ctrl_wr && !ctrl_bits[0]));
    // R5: enables are never set in standard mode
    a_r5_ie_off_in_std: assert property (@(posedge clk) disable iff (!rst_n)
        !smart_o |-> !host_ie_o && !dsp_ie_o);
endmodule

// File: rtl/hdm_mailbox.sv
module hdm_mailbox
    import hdm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic          full_o,
    output logic [DW-1:0] data_o
);
    mb_e           state_q, state_d;
    logic [DW-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_EMPTY: if (wr_i) state_d = MB_FULL;
            MB_FULL:  if (!wr_i && rd_i) state_d = MB_EMPTY;
        endcase
        if (flush_i) state_d = MB_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MB_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr_i && !flush_i) data_q <= wdata_i;
        end
    end

    always_comb begin
        full_o = (state_q == MB_FULL);
        data_o = data_q;
    end

    // R8: a write always leaves the box full
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !flush_i) |=> full_o);
    // R6/R7: the flag only drops after a read or a flush
    a_r7_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_o) |-> $past(rd_i || flush_i));
    // R6: held word is stable without a write
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(data_o));
endmodule

// File: rtl/hdm_bio.sv
module hdm_bio #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] pins_i,
    output logic [DW-1:0] pins_o,
    output logic [DW-1:0] sample_o
);
    logic [DW-1:0] out_q, in_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            in_q  <= '0;
        end else begin
            in_q <= pins_i;
            if (we_i) out_q <= wdata_i;
        end
    end

    assign pins_o   = out_q;
    assign sample_o = in_q;

    // R11: output latch only moves on a DSP write
    a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(pins_o));
endmodule

// File: rtl/hostdsp_mailbox_regs.sv
module hostdsp_mailbox_regs
    import hdm_pkg::*;
#(
    parameter int DW            = 16,
    parameter int HAW           = 11,
    parameter int DAW           = 8,
    parameter bit HOST_IO_ALIAS = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_sel,
    input  logic           h_io,
    input  logic           h_we,
    input  logic [HAW-1:0] h_addr,
    input  logic [DW-1:0]  h_wdata,
    output logic [DW-1:0]  h_rdata,
    input  logic           d_sel,
    input  logic           d_we,
    input  logic [DAW-1:0] d_addr,
    input  logic [DW-1:0]  d_wdata,
    output logic [DW-1:0]  d_rdata,
    input  logic [DW-1:0]  bio_pins_i,
    output logic [DW-1:0]  bio_pins_o,
    output logic [DW-1:0]  syscfg_o,
    output logic           smart_mode_o,
    output logic           host_irq_o,
    output logic           dsp_irq_o
);
    localparam int PAD = DW - 3;

    logic smart, host_ie, dsp_ie;
    logic h_mem, h_ioacc, h_reg, h_sig;
    logic sig_wr, ctrl_wr, rx_post, tx_take;
    logic d_ok, tx_post, rx_take, bio_we, cfg_we;
    logic tx_full, rx_full;
    logic [DW-1:0] tx_data, rx_data, bio_sample, status_w, cfg_q, cfg_view;

    // host space decode; the I/O alias is a build-time variant
    assign h_mem = h_sel && !h_io;
    generate
        if (HOST_IO_ALIAS) begin : g_io_alias
            assign h_ioacc = h_sel && h_io;
        end else begin : g_no_alias
            assign h_ioacc = 1'b0;
        end
    endgenerate
    assign h_reg = (h_mem || h_ioacc) && smart;
    assign h_sig = h_mem && (h_addr == HAW'(H_SIG));

    assign sig_wr  = h_sig && h_we;
    assign ctrl_wr = h_reg && h_we  && (h_addr == HAW'(H_CTRL));
    assign rx_post = h_reg && h_we  && (h_addr == HAW'(H_RX));
    assign tx_take = h_reg && !h_we && (h_addr == HAW'(H_TX));

    // DSP side is inert outside smart mode
    assign d_ok    = d_sel && smart;
    assign tx_post = d_ok && d_we  && (d_addr == DAW'(D_TX));
    assign rx_take = d_ok && !d_we && (d_addr == DAW'(D_RX));
    assign bio_we  = d_ok && d_we  && (d_addr == DAW'(D_BIO));
    assign cfg_we  = d_ok && d_we  && (d_addr == DAW'(D_CFG));

    hdm_mode_fsm #(.DW(DW)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_wr    (sig_wr),
        .sig_data  (h_wdata),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (h_wdata[2:0]),
        .smart_o   (smart),
        .host_ie_o (host_ie),
        .dsp_ie_o  (dsp_ie)
    );

    // host-bound mailbox: DSP posts, host takes
    hdm_mailbox #(.DW(DW)) u_tx_box (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (!smart),
        .wr_i    (tx_post),
        .wdata_i (d_wdata),
        .rd_i    (tx_take),
        .full_o  (tx_full),
        .data_o  (tx_data)
    );

    // DSP-bound mailbox: host posts, DSP takes
    hdm_mailbox #(.DW(DW)) u_rx_box (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (!smart),
        .wr_i    (rx_post),
        .wdata_i (h_wdata),
        .rd_i    (rx_take),
        .full_o  (rx_full),
        .data_o  (rx_data)
    );

    hdm_bio #(.DW(DW)) u_bio (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (bio_we),
        .wdata_i  (d_wdata),
        .pins_i   (bio_pins_i),
        .pins_o   (bio_pins_o),
        .sample_o (bio_sample)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= d_wdata;
    end
    assign cfg_view = {cfg_q[DW-1:1], 1'b1};
    assign syscfg_o = cfg_view;

    assign status_w = {{PAD{1'b0}}, smart, rx_full, tx_full};

    // host read mux
    always_comb begin
        h_rdata = '0;
        if (h_sig && !h_we) begin
            h_rdata = smart ? DW'(SIG_KEY) : '0;
        end else if (h_reg && !h_we) begin
            if (h_addr == HAW'(H_CTRL))      h_rdata = {{PAD{1'b0}}, dsp_ie, host_ie, 1'b1};
            else if (h_addr == HAW'(H_STAT)) h_rdata = status_w;
            else if (h_addr == HAW'(H_TX))   h_rdata = tx_data;
        end
    end

    // DSP read mux
    always_comb begin
        d_rdata = '0;
        if (d_ok && !d_we) begin
            if (d_addr == DAW'(D_RX))        d_rdata = rx_data;
            else if (d_addr == DAW'(D_STAT)) d_rdata = status_w;
            else if (d_addr == DAW'(D_BIO))  d_rdata = bio_sample;
            else if (d_addr == DAW'(D_CFG))  d_rdata = cfg_view;
        end
    end

    assign smart_mode_o = smart;
    assign host_irq_o   = smart && host_ie && tx_full;
    assign dsp_irq_o    = smart && dsp_ie && rx_full;

    // R4: the configuration word does not move in standard mode
    a_r4_cfg_frozen_std: assert property (@(posedge clk) disable iff (!rst_n)
        !smart_mode_o |=> $stable(syscfg_o));
    // R9: an interrupt rising means its mailbox was just posted or its enable just set
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq_o) |-> $past(tx_post || ctrl_wr));
endmodule

// File: tb/hostdsp_mailbox_regs_test.sv
module hostdsp_mailbox_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_sel = 0, h_io = 0, h_we = 0;
    logic [10:0] h_addr = '0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        d_sel = 0, d_we = 0;
    logic [7:0]  d_addr = '0;
    logic [15:0] d_wdata = '0;
    logic [15:0] d_rdata;
    logic [15:0] bio_pins_i = '0;
    logic [15:0] bio_pins_o, syscfg_o;
    logic        smart_mode_o, host_irq_o, dsp_irq_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk; // 125 MHz

    hostdsp_mailbox_regs uut (
        .clk(clk), .rst_n(rst_n),
        .h_sel(h_sel), .h_io(h_io), .h_we(h_we), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .d_sel(d_sel), .d_we(d_we), .d_addr(d_addr),
        .d_wdata(d_wdata), .d_rdata(d_rdata),
        .bio_pins_i(bio_pins_i), .bio_pins_o(bio_pins_o), .syscfg_o(syscfg_o),
        .smart_mode_o(smart_mode_o), .host_irq_o(host_irq_o), .dsp_irq_o(dsp_irq_o)
    );

    // op: 0 host mem write, 1 host mem read, 2 DSP write, 3 DSP read,
    //     4 host I/O read, 5 host I/O write
    // entry = {op, addr, wdata, expected, requirement number}
    localparam int NV = 31;
    localparam logic [50:0] VEC [NV] = '{
        {3'd1, 12'h002, 16'h0000, 16'h0000, 4'd4},  // R4 control hidden
        {3'd0, 12'h002, 16'h0007, 16'h0000, 4'd4},  // R4 write ignored
        {3'd0, 12'h400, 16'h1234, 16'h0000, 4'd3},  // R3 wrong key
        {3'd1, 12'h400, 16'h0000, 16'h0000, 4'd3},  // R3 still standard
        {3'd3, 12'h054, 16'h0000, 16'h0000, 4'd4},  // R4 DSP read gated
        {3'd2, 12'h053, 16'hFFFF, 16'h0000, 4'd4},  // R4 DSP write gated
        {3'd0, 12'h400, 16'hA320, 16'h0000, 4'd2},  // R2 key
        {3'd1, 12'h400, 16'h0000, 16'hA320, 4'd2},
        {3'd1, 12'h002, 16'h0000, 16'h0001, 4'd2},
        {3'd0, 12'h002, 16'h0007, 16'h0000, 4'd9},  // R9 enables
        {3'd1, 12'h002, 16'h0000, 16'h0007, 4'd9},
        {3'd0, 12'h400, 16'h5555, 16'h0000, 4'd3},  // R3 smart kept
        {3'd1, 12'h002, 16'h0000, 16'h0007, 4'd3},
        {3'd0, 12'h008, 16'hBEEF, 16'h0000, 4'd6},  // R6
        {3'd1, 12'h004, 16'h0000, 16'h0006, 4'd6},
        {3'd3, 12'h052, 16'h0000, 16'h0006, 4'd6},
        {3'd3, 12'h051, 16'h0000, 16'hBEEF, 4'd6},
        {3'd1, 12'h004, 16'h0000, 16'h0004, 4'd6},
        {3'd2, 12'h050, 16'h1357, 16'h0000, 4'd7},  // R7
        {3'd1, 12'h004, 16'h0000, 16'h0005, 4'd7},
        {3'd1, 12'h006, 16'h0000, 16'h1357, 4'd7},
        {3'd1, 12'h004, 16'h0000, 16'h0004, 4'd7},
        {3'd0, 12'h00A, 16'hFFFF, 16'h0000, 4'd10}, // R10
        {3'd1, 12'h00A, 16'h0000, 16'h0000, 4'd10},
        {3'd2, 12'h055, 16'hFFFF, 16'h0000, 4'd10},
        {3'd3, 12'h058, 16'h0000, 16'h0000, 4'd10},
        {3'd1, 12'h004, 16'h0000, 16'h0004, 4'd10},
        {3'd2, 12'h054, 16'h00F0, 16'h0000, 4'd12}, // R12
        {3'd3, 12'h054, 16'h0000, 16'h00F1, 4'd12},
        {3'd1, 12'h008, 16'h0000, 16'h0000, 4'd6},
        {3'd4, 12'h002, 16'h0000, 16'h0007, 4'd13}  // R13 alias
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        h_sel = 0; h_io = 0; h_we = 0; d_sel = 0; d_we = 0;
    endtask

    task automatic acc(input logic [2:0] op, input logic [11:0] a, input logic [15:0] d,
                       input logic [15:0] e, input string tag);
        @(negedge clk);
        if (op == 3'd2 || op == 3'd3) begin
            d_sel = 1; d_we = (op == 3'd2); d_addr = a[7:0]; d_wdata = d;
        end else begin
            h_sel = 1; h_io = (op >= 3'd4); h_we = (op == 3'd0 || op == 3'd5);
            h_addr = a[10:0]; h_wdata = d;
        end
        #2;
        if (op == 3'd1 || op == 3'd4) chk(tag, h_rdata, e);
        if (op == 3'd3) chk(tag, d_rdata, e);
        @(posedge clk); #1;
        idle();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 smart", {15'b0, smart_mode_o}, 16'h0);
        chk("R1 irqs", {14'b0, host_irq_o, dsp_irq_o}, 16'h0);
        chk("R1 syscfg", syscfg_o, 16'h0001);
        chk("R1 bio", bio_pins_o, 16'h0);
        acc(3'd1, 12'h400, 16'h0, 16'h0, "R1 sig read");

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][50:48], VEC[i][47:36], VEC[i][35:20], VEC[i][19:4],
                $sformatf("R%0d vec%0d", VEC[i][3:0], i));
        end
        chk("R4 bio latch untouched in standard", bio_pins_o, 16'h0);
        chk("R12 syscfg pins", syscfg_o, 16'h00F1);

        // R13 alias post into DSP-bound box
        acc(3'd5, 12'h008, 16'h2468, 16'h0, "R13");
        acc(3'd1, 12'h004, 16'h0, 16'h0006, "R13 status");
        acc(3'd3, 12'h051, 16'h0, 16'h2468, "R13 dsp read");

        // R9 interrupts (enables 0x7 set)
        acc(3'd2, 12'h050, 16'hAAAA, 16'h0, "R9");
        @(negedge clk);
        chk("R9 host irq", {15'b0, host_irq_o}, 16'h1);
        chk("R9 dsp irq idle", {15'b0, dsp_irq_o}, 16'h0);
        acc(3'd0, 12'h008, 16'h5555, 16'h0, "R9");
        @(negedge clk);
        chk("R9 dsp irq", {15'b0, dsp_irq_o}, 16'h1);
        acc(3'd0, 12'h002, 16'h0001, 16'h0, "R9 disable");
        @(negedge clk);
        chk("R9 irqs masked", {14'b0, host_irq_o, dsp_irq_o}, 16'h0);
        acc(3'd1, 12'h004, 16'h0, 16'h0007, "R9 flags kept");

        // R8 collisions on both boxes
        @(negedge clk);
        h_sel = 1; h_we = 0; h_addr = 11'h006;
        d_sel = 1; d_we = 1; d_addr = 8'h50; d_wdata = 16'h4242;
        @(posedge clk); #1; idle();
        acc(3'd1, 12'h004, 16'h0, 16'h0007, "R8 tx stays full");
        acc(3'd1, 12'h006, 16'h0, 16'h4242, "R8 tx new word");
        @(negedge clk);
        h_sel = 1; h_we = 1; h_addr = 11'h008; h_wdata = 16'h7777;
        d_sel = 1; d_we = 0; d_addr = 8'h51;
        @(posedge clk); #1; idle();
        acc(3'd1, 12'h004, 16'h0, 16'h0006, "R8 rx stays full");
        acc(3'd3, 12'h051, 16'h0, 16'h7777, "R8 rx new word");

        // R11 bit I/O
        bio_pins_i = 16'hA5C3;
        repeat (2) @(posedge clk);
        acc(3'd3, 12'h053, 16'h0, 16'hA5C3, "R11 sample");
        acc(3'd2, 12'h053, 16'h0F0F, 16'h0, "R11");
        @(negedge clk);
        chk("R11 pins", bio_pins_o, 16'h0F0F);

        // R5 leave smart with state pending
        acc(3'd0, 12'h002, 16'h0007, 16'h0, "R5");
        acc(3'd0, 12'h008, 16'h1111, 16'h0, "R5");
        acc(3'd2, 12'h050, 16'h2222, 16'h0, "R5");
        acc(3'd0, 12'h002, 16'h0000, 16'h0, "R5 clear");
        @(negedge clk);
        chk("R5 standard", {15'b0, smart_mode_o}, 16'h0);
        chk("R5 irqs", {14'b0, host_irq_o, dsp_irq_o}, 16'h0);
        acc(3'd1, 12'h004, 16'h0, 16'h0, "R5 status hidden");
        // R13 signature not reachable through I/O space
        acc(3'd5, 12'h400, 16'hA320, 16'h0, "R13");
        @(negedge clk);
        chk("R13 io key ignored", {15'b0, smart_mode_o}, 16'h0);
        acc(3'd0, 12'h400, 16'hA320, 16'h0, "R5 reenter");
        acc(3'd1, 12'h004, 16'h0, 16'h0004, "R5 boxes flushed");
        acc(3'd1, 12'h002, 16'h0, 16'h0001, "R5 enables cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule